// File: doc/BRIEF.md
# Filtered Receive Packet FIFO

This block is a byte-wide buffer placed between a network receive engine and a DMA consumer. Every byte is written together with a parity bit the block generates itself, from the first byte of the packet, which is the first destination-address byte. A packet stays provisional, and cannot be seen on the read side, until an address filter gives its verdict. An accept makes the buffered bytes visible and lets the rest of the packet stream through with no further wait. A reject, a receive error or an overflow before the verdict rolls the write pointer back to where the packet began. Complete packets already in the buffer are kept. A counter reports how many bytes of the current packet have been stored.

On the read side, a valid/ready stream presents one byte at a time. Each byte carries its parity, an end-of-packet mark and a discard mark. A packet that ends with a CRC error is delivered with the discard mark on its last byte. A packet that fails after it was accepted cannot be recalled, because some of its bytes may already have been read. Such a packet is closed by one extra terminator entry that carries both marks. Back-pressure on the write side follows one rule: `in_ready` low means no room. A byte offered while it is low is lost and counts as a receive error. On the read side, a byte moves when `out_valid` and `out_ready` are both high, and `out_valid` never drops until the byte has moved.

Top module: `rx_pkt_fifo`

## Requirements
- R1: `in_ready` is low exactly when 16 entries (provisional and visible together) are held or a terminator is waiting for room. `out_valid` is high whenever at least one visible entry is unread.
- R2: Each output entry carries `out_par` such that `out_par` XOR all bits of `out_data` is 0 (even parity). This applies to every byte, starting with the first byte of a packet.
- R3: `rx_byte_cnt` becomes 1 on the first stored byte of a packet and rises by one for each further stored byte. It saturates at 2047 and holds its value between packets.
- R4: Bytes of a packet with no verdict yet are not visible. Once the accept is sampled, they appear on the read side in the next cycle.
- R5: On a reject, all stored bytes of the current packet are removed, and the remaining bytes up to `in_last` are dropped. Entries of earlier packets are untouched.
- R6: `rx_err` before the verdict has the same effect as a reject. The byte offered in that cycle is not stored.
- R7: A packet that reaches `in_last` with no verdict is removed as if it had been rejected.
- R8: The last byte of an accepted packet has `out_eof`=1 and `out_toss` equal to `in_crc_err` sampled with `in_last`. All other bytes have both marks at 0.
- R9: `rx_err` after the accept drops the rest of the packet and appends one terminator entry with data 0x00, `out_eof`=1 and `out_toss`=1.
- R10: A byte offered while `in_ready` is low is a receive error. Before the verdict it flushes the packet. After the accept it yields the terminator, which is held back until room exists.
- R11: A filter verdict sampled while no packet is pending (idle, passing or dropping) has no effect.
- R12: After reset the buffer is empty, `out_valid`=0, `in_ready`=1 and `rx_byte_cnt`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte offered by the receive engine |
| in_ready | output | 1 | Room for a byte |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | Offered byte is the last of its packet |
| in_crc_err | input | 1 | CRC failed; sampled with `in_last` |
| rx_err | input | 1 | Receive error in the current packet |
| filt_valid | input | 1 | Address-filter verdict present |
| filt_accept | input | 1 | Verdict: 1 accept, 0 reject |
| out_valid | output | 1 | Visible entry available |
| out_ready | input | 1 | Consumer takes the entry |
| out_data | output | 8 | Entry byte |
| out_par | output | 1 | Stored parity of the byte |
| out_eof | output | 1 | Entry ends a packet |
| out_toss | output | 1 | Packet must be discarded |
| rx_byte_cnt | output | 11 | Bytes stored for the current packet |

## Verification
The hardest overlap is a flush or terminator in the same cycle as other write-side work. The bench fills the buffer with a pending packet, and separately with an accepted packet while the consumer is stalled. It then offers one byte too many. It judges that the pending bytes vanish while earlier entries remain. It also judges that, after an accept, the terminator is deferred with `in_ready` low until a read frees a slot. Random traffic also lets a verdict and `rx_err` land on the same byte, together with concurrent reads. A bench model then predicts the exact output stream.

// File: rtl/rx_pkt_fifo_pkg.sv
package rx_pkt_fifo_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_PASS = 2'd2,
    ST_DROP = 2'd3
  } rx_state_e;

  typedef struct packed {
    logic              toss;
    logic              eof;
    logic [BYTE_W-1:0] data;
  } rx_word_t;

  localparam rx_word_t TERM_WORD = '{toss: 1'b1, eof: 1'b1, data: '0};
endpackage

// File: rtl/rx_pf_store.sv
module rx_pf_store
  import rx_pkt_fifo_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter bit          ODD_PAR = 1'b0,
  localparam int unsigned AW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  rx_word_t      wword,
  input  logic [AW-1:0] raddr,
  output rx_word_t      rword,
  output logic          rpar
);
  localparam int unsigned EW = $bits(rx_word_t) + 1;

  logic          wpar;
  logic [EW-1:0] mem [DEPTH];

  generate
    if (ODD_PAR) begin : g_odd
      assign wpar = ~(^wword.data);
    end else begin : g_even
      assign wpar = ^wword.data;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= {wpar, wword};
  end

  assign rword = rx_word_t'(mem[raddr][EW-2:0]);
  assign rpar  = mem[raddr][EW-1];
endmodule

// File: rtl/rx_pf_count.sv
module rx_pf_count #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sop,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (sop)          cnt <= inc ? CNT_W'(1) : '0;
    else if (inc && cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
  end

  // R3: the count only moves downward when a new packet starts
  a_r3_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !sop |=> cnt >= $past(cnt));
  // R3: saturation holds the ceiling
  a_r3_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (!sop && cnt == CNT_MAX) |=> cnt == CNT_MAX);
endmodule

// File: rtl/rx_pf_ctrl.sv
module rx_pf_ctrl
  import rx_pkt_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  input  logic              in_crc_err,
  input  logic              rx_err,
  input  logic              filt_valid,
  input  logic              filt_accept,
  input  logic              out_ready,
  output logic              in_ready,
  output logic              out_valid,
  output logic              we,
  output logic [AW-1:0]     wr_addr,
  output rx_word_t          wr_word,
  output logic [AW-1:0]     rd_addr,
  output logic              sop,
  output logic              byte_acc
);
  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);
  localparam logic [PW-1:0] ONE      = PW'(1);

  rx_state_e     st_q, st_d, st_e;
  logic [PW-1:0] wr_q, wr_d, cm_q, cm_d, rd_q, pk_q, pk_e, wr_t;
  logic          term_q, term_d;
  logic          full, ovf, err, last_b, dec_acc, dec_rej, flush, term_go;

  assign full     = (wr_q - rd_q) == FULL_LVL;
  assign in_ready = !full && !term_q;
  assign ovf      = in_valid && !in_ready;
  assign err      = rx_err || ovf;
  assign last_b   = in_valid && in_last;
  assign sop      = (st_q == ST_IDLE) && in_valid;
  assign st_e     = sop ? ST_PEND : st_q;
  assign dec_acc  = filt_valid && filt_accept && (st_e == ST_PEND);
  assign dec_rej  = filt_valid && !filt_accept && (st_e == ST_PEND);
  assign term_go  = term_q && !full;
  assign wr_t     = term_go ? wr_q + ONE : wr_q;
  assign pk_e     = sop ? wr_t : pk_q;

  assign out_valid = cm_q != rd_q;
  assign rd_addr   = rd_q[AW-1:0];
  assign wr_addr   = wr_q[AW-1:0];

  always_comb begin
    st_d     = st_q;
    wr_d     = wr_q;
    cm_d     = cm_q;
    term_d   = term_q;
    we       = 1'b0;
    byte_acc = 1'b0;
    flush    = 1'b0;
    wr_word  = '{toss: in_last & in_crc_err, eof: in_last, data: in_data};
    if (term_go) begin
      we      = 1'b1;
      wr_word = TERM_WORD;
      wr_d    = wr_q + ONE;
      cm_d    = wr_q + ONE;
      term_d  = 1'b0;
    end
    unique case (st_e)
      ST_PEND: begin
        if (err || dec_rej) begin
          flush = 1'b1;
          wr_d  = pk_e;
          st_d  = last_b ? ST_IDLE : ST_DROP;
        end else begin
          st_d = ST_PEND;
          if (in_valid) begin
            we       = 1'b1;
            byte_acc = 1'b1;
            wr_d     = wr_q + ONE;
          end
          if (dec_acc) begin
            cm_d = wr_d;
            st_d = last_b ? ST_IDLE : ST_PASS;
          end else if (last_b) begin
            flush = 1'b1;
            wr_d  = pk_e;
            st_d  = ST_IDLE;
          end
        end
      end
      ST_PASS: begin
        if (err) begin
          st_d = last_b ? ST_IDLE : ST_DROP;
          if (!full) begin
            we      = 1'b1;
            wr_word = TERM_WORD;
            wr_d    = wr_q + ONE;
            cm_d    = wr_q + ONE;
          end else begin
            term_d = 1'b1;
          end
        end else if (in_valid) begin
          we       = 1'b1;
          byte_acc = 1'b1;
          wr_d     = wr_q + ONE;
          cm_d     = wr_q + ONE;
          if (in_last) st_d = ST_IDLE;
        end
      end
      ST_DROP: if (last_b) st_d = ST_IDLE;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wr_q   <= '0;
      cm_q   <= '0;
      rd_q   <= '0;
      pk_q   <= '0;
      term_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      wr_q   <= wr_d;
      cm_q   <= cm_d;
      term_q <= term_d;
      if (sop) pk_q <= pk_e;
      if (out_valid && out_ready) rd_q <= rd_q + ONE;
    end
  end

  // R1: nothing is written into a full buffer
  a_r1_no_write_full: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !we);
  // R4: while a verdict is pending the visible region ends at the packet start
  a_r4_pending_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PEND) |-> (cm_q == pk_q));
  // R5: a flush leaves exactly the visible entries behind
  a_r5_flush_to_commit: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (wr_q == cm_q));
  // R10: a deferred terminator is written as soon as room appears
  a_r10_term_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (term_q && !full) |=> !term_q);
  // R10: a deferred terminator never coexists with an accepted packet in flight
  a_r10_term_not_passing: assert property (@(posedge clk) disable iff (!rst_n)
    term_q |-> (st_q != ST_PASS));
endmodule

// File: rtl/rx_pkt_fifo.sv
module rx_pkt_fifo
  import rx_pkt_fifo_pkg::*;
#(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned CNT_W      = 11,
  parameter bit          ODD_PARITY = 1'b0,
  localparam int unsigned AW        = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  input  logic             in_crc_err,
  input  logic             rx_err,
  input  logic             filt_valid,
  input  logic             filt_accept,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_par,
  output logic             out_eof,
  output logic             out_toss,
  output logic [CNT_W-1:0] rx_byte_cnt
);
  logic          we, sop, byte_acc;
  logic [AW-1:0] wr_addr, rd_addr;
  rx_word_t      wr_word, rd_word;

  rx_pf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_last    (in_last),
    .in_crc_err (in_crc_err),
    .rx_err     (rx_err),
    .filt_valid (filt_valid),
    .filt_accept(filt_accept),
    .out_ready  (out_ready),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .we         (we),
    .wr_addr    (wr_addr),
    .wr_word    (wr_word),
    .rd_addr    (rd_addr),
    .sop        (sop),
    .byte_acc   (byte_acc)
  );

  rx_pf_store #(.DEPTH(DEPTH), .ODD_PAR(ODD_PARITY)) u_store (
    .clk  (clk),
    .we   (we),
    .waddr(wr_addr),
    .wword(wr_word),
    .raddr(rd_addr),
    .rword(rd_word),
    .rpar (out_par)
  );

  rx_pf_count #(.CNT_W(CNT_W)) u_count (
    .clk  (clk),
    .rst_n(rst_n),
    .sop  (sop),
    .inc  (byte_acc),
    .cnt  (rx_byte_cnt)
  );

  assign out_data = rd_word.data;
  assign out_eof  = rd_word.eof;
  assign out_toss = rd_word.toss;

  // R2: parity presented with every visible entry matches its byte
  a_r2_out_parity: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_par == ((^out_data) ^ ODD_PARITY)));
  // R8: a discard mark only ever comes with an end mark
  a_r8_toss_with_eof: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_toss) |-> out_eof);
  // R1: an offered entry stays until taken
  a_r1_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: tb/rx_pkt_fifo_tb_top.sv
`timescale 1ns/1ps
module rx_pkt_fifo_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_last = 1'b0, in_crc_err = 1'b0, rx_err = 1'b0;
  logic        filt_valid = 1'b0, filt_accept = 1'b0, out_ready = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, out_valid, out_par, out_eof, out_toss;
  logic [7:0]  out_data;
  logic [10:0] rx_byte_cnt;

  always #4 clk = ~clk;

  rx_pkt_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_crc_err(in_crc_err), .rx_err(rx_err),
    .filt_valid(filt_valid), .filt_accept(filt_accept), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_par(out_par),
    .out_eof(out_eof), .out_toss(out_toss), .rx_byte_cnt(rx_byte_cnt)
  );

  int          n_tests = 0, n_fail = 0, cyc = 0, rd_prob = 0;
  bit          done = 1'b0;
  string       cur_req = "R8";
  logic [10:0] exp_q[$], prov_q[$];
  int          m_st = 0;
  int          m_cnt = 0;

  always @(posedge clk) cyc++;

  task automatic chk(input string req, input int act, input int exp_v);
    n_tests++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  function automatic logic [10:0] mk(input logic [7:0] d, input bit last, input bit crc);
    return {last & crc, last, ^d, d};
  endfunction

  // model of the requirements: state 0 idle, 1 pending, 2 passing, 3 dropping
  function automatic void model(input logic [7:0] d, input bit last, input bit crc,
                                input bit err, input bit fv, input bit fa);
    if (m_st == 0) begin m_st = 1; m_cnt = 0; prov_q.delete(); end
    if (m_st == 1) begin
      if (err || (fv && !fa)) begin prov_q.delete(); m_st = last ? 0 : 3; end
      else begin
        prov_q.push_back(mk(d, last, crc));
        if (m_cnt < 2047) m_cnt++;
        if (fv && fa) begin
          foreach (prov_q[k]) exp_q.push_back(prov_q[k]);
          prov_q.delete();
          m_st = last ? 0 : 2;
        end else if (last) begin prov_q.delete(); m_st = 0; end
      end
    end else if (m_st == 2) begin
      if (err) begin exp_q.push_back(11'h600); m_st = last ? 0 : 3; end
      else begin
        exp_q.push_back(mk(d, last, crc));
        if (m_cnt < 2047) m_cnt++;
        if (last) m_st = 0;
      end
    end else if (m_st == 3) begin
      if (last) m_st = 0;
    end
  endfunction

  task automatic drive(input logic [7:0] d, input bit last, input bit crc,
                       input bit err, input bit fv, input bit fa);
    in_valid = 1'b1; in_data = d; in_last = last; in_crc_err = crc;
    rx_err = err; filt_valid = fv; filt_accept = fa;
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0; in_crc_err = 1'b0;
    rx_err = 1'b0; filt_valid = 1'b0; filt_accept = 1'b0;
  endtask

  task automatic put(input logic [7:0] d, input bit last, input bit crc,
                     input bit err, input bit fv, input bit fa);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    model(d, last, crc, err, fv, fa);
    drive(d, last, crc, err, fv, fa);
  endtask

  // byte offered without waiting: an overflow when in_ready is low (R10)
  task automatic force_byte(input logic [7:0] d, input bit last);
    @(negedge clk);
    model(d, last, 1'b0, !in_ready, 1'b0, 1'b0);
    drive(d, last, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic drain(input string req);
    int w;
    rd_prob = 100;
    w = 0;
    while ((exp_q.size() != 0 || out_valid) && w < 3000) begin @(negedge clk); w++; end
    chk(req, exp_q.size(), 0);
  endtask

  // consumer: decide ready, compare the entry that moves at the next edge
  always @(negedge clk) begin
    out_ready = (($urandom % 100) < rd_prob);
    if (out_valid && out_ready && !done) begin
      if (exp_q.size() == 0) chk({cur_req, " unexpected entry"}, {out_toss, out_eof, out_par, out_data}, 0);
      else begin
        logic [10:0] e;
        e = exp_q.pop_front();
        chk(cur_req, {out_toss, out_eof, out_par, out_data}, e);
        chk("R2", int'(out_par), int'(^out_data));
      end
    end
  end

  task automatic rand_traffic(input int npk);
    for (int p = 0; p < npk; p++) begin
      int len, dpos, epos;
      bit has_dec, acc, crc;
      len = 1 + $urandom % 24;
      dpos = $urandom % 14;
      has_dec = (dpos < len) && (dpos < 11);
      if (!has_dec && len > 12) len = 12;
      acc = ($urandom % 4) != 0;
      epos = (($urandom % 6) == 0) ? int'($urandom % len) : -1;
      crc = ($urandom % 5) == 0;
      rd_prob = 20 + $urandom % 80;
      for (int i = 0; i < len; i++) begin
        bit fv, stray;
        fv = has_dec && (i == dpos);
        stray = !fv && (($urandom % 10) == 0);
        put(8'($urandom), i == len - 1, crc && (i == len - 1), i == epos,
            fv || stray, fv ? acc : 1'($urandom));
      end
      @(negedge clk);
      chk("R3", rx_byte_cnt, m_cnt);
      repeat ($urandom % 3) @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12", out_valid, 0);
    chk("R12", in_ready, 1);
    chk("R12", rx_byte_cnt, 0);

    // R4 bytes hidden until accept, visible one cycle later
    cur_req = "R4";
    rd_prob = 0;
    put(8'h11, 0, 0, 0, 0, 0);
    put(8'h22, 0, 0, 0, 0, 0);
    put(8'h33, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R4", out_valid, 0);
    put(8'h44, 0, 0, 0, 1, 1);
    @(negedge clk);
    chk("R4", out_valid, 1);
    put(8'h55, 1, 1, 0, 0, 0);
    drain("R8");

    // R5 reject keeps earlier packet; R11 stray verdict while passing ignored
    cur_req = "R5";
    rd_prob = 0;
    put(8'hA0, 0, 0, 0, 1, 1);
    put(8'hA1, 1, 0, 0, 0, 0);
    put(8'hB0, 0, 0, 0, 0, 0);
    put(8'hB1, 0, 0, 0, 0, 0);
    put(8'hB2, 0, 0, 0, 1, 0);
    put(8'hB3, 1, 0, 0, 0, 0);
    @(negedge clk);
    chk("R5", rx_byte_cnt, 2);
    chk("R5", out_valid, 1);
    put(8'hC0, 0, 0, 0, 1, 1);
    put(8'hC1, 0, 0, 0, 1, 0);
    put(8'hC2, 1, 0, 0, 0, 0);
    cur_req = "R11";
    drain("R11");

    // R6 error before verdict, R7 no verdict at end
    cur_req = "R6";
    put(8'hD0, 0, 0, 0, 0, 0);
    put(8'hD1, 0, 0, 1, 1, 1);
    put(8'hD2, 1, 0, 0, 0, 0);
    put(8'hE0, 0, 0, 0, 0, 0);
    put(8'hE1, 1, 0, 0, 0, 0);
    @(negedge clk);
    chk("R7", out_valid, 0);
    chk("R7", rx_byte_cnt, 2);
    drain("R6");

    // R9 error after accept gives terminator
    cur_req = "R9";
    put(8'hF0, 0, 0, 0, 1, 1);
    put(8'hF1, 0, 0, 1, 0, 0);
    put(8'hF2, 1, 0, 0, 0, 0);
    drain("R9");

    // R10 overflow before the verdict flushes, R1 full
    cur_req = "R10";
    rd_prob = 0;
    put(8'h01, 0, 0, 0, 1, 1);
    put(8'h02, 1, 0, 0, 0, 0);
    for (int i = 0; i < 14; i++) put(8'(i), 0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R1", in_ready, 0);
    force_byte(8'h99, 0);
    @(negedge clk);
    chk("R10", in_ready, 1);
    chk("R10", out_valid, 1);
    put(8'h98, 1, 0, 0, 0, 0);
    drain("R10");

    // R10 overflow after accept: terminator waits for room
    rd_prob = 0;
    put(8'h40, 0, 0, 0, 1, 1);
    for (int i = 1; i < 16; i++) put(8'(8'h40 + i), 0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R1", in_ready, 0);
    force_byte(8'h77, 0);
    @(negedge clk);
    chk("R10", in_ready, 0);
    force_byte(8'h78, 1);
    drain("R10");
    @(negedge clk);
    chk("R1", in_ready, 1);

    // R3 saturation and clear at next packet
    cur_req = "R3";
    rd_prob = 100;
    for (int i = 0; i < 2100; i++) put(8'(i * 7), i == 2099, 0, 0, i == 0, 1);
    @(negedge clk);
    chk("R3", rx_byte_cnt, 2047);
    put(8'h10, 0, 0, 0, 1, 1);
    put(8'h11, 0, 0, 0, 0, 0);
    put(8'h12, 1, 0, 0, 0, 0);
    @(negedge clk);
    chk("R3", rx_byte_cnt, 3);
    drain("R3");

    // mixed random traffic
    cur_req = "R8";
    rand_traffic(300);
    drain("R8");
    @(negedge clk);
    chk("R1", out_valid, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule